// File: doc/BRIEF.md
# Snoop Intervention Read Responder

This block serves line reads on a shared multiprocessor system bus that joins several second-level caches and one memory. When a read is presented, the block looks at the snoop state that every other cache reports for the line. It then picks one source for the data. A cache that holds the line supplies it, and memory is bypassed. When no other cache holds the line, memory supplies it instead.

The choice of source sets the timing of the reply. A line moves as four data beats. A cache-to-cache transfer starts after a short lead time, and a memory transfer starts after a longer one. Once the first beat appears, the remaining beats follow on consecutive cycles.

Only one read is in flight at a time. Alongside each beat, the block reports where the data came from and which cache supplied it, if any. It also reports the line address being served. The beat data itself is taken from the chosen source's data input in the same cycle and passed through.

Top module: `snoop_read_responder`

## Requirements
- R1: While reset is low and right after it, `req_ready_o` is 1, `beat_valid_o` is 0 and `beat_data_o` is zero. A request presented during reset is not accepted.
- R2: Each cache reports 2 snoop bits at `snoop_i[2*i+1:2*i]`. Bit 1 set (codes 10 and 11) means modified, and 01 means shared. A cache other than the requester that reports modified supplies the line: `src_mem_o` is 0 and `src_cache_o` is its index.
- R3: If no other cache reports modified but one reports shared (code 01), that cache supplies the line and memory is not used.
- R4: When a modified holder and shared holders both report, the modified holder supplies the line.
- R5: Among several holders of the same class, the lowest-numbered cache is chosen.
- R6: The snoop bits of the cache named by `req_id_i` are ignored. The requester is never chosen, even when it reports modified or shared.
- R7: When no other cache reports modified or shared, memory supplies the line and `src_mem_o` is 1.
- R8: For a cache-sourced read accepted at the clock edge that ends request cycle 0, beat 0 is valid in cycle C2C_LAT (6). Beats 1, 2 and 3 follow in the next three cycles, with `beat_idx_o` counting 0 to 3.
- R9: For a memory-sourced read, beat 0 is valid in cycle MEM_LAT (14), and the next three beats follow in consecutive cycles.
- R10: A request is accepted only when `req_ready_o` is 1. Ready drops in cycle 1 and returns in the cycle after beat 3. Requests presented while it is 0 are ignored, and the source outputs stay constant through the burst.
- R11: During a beat, `beat_data_o` equals the chosen source's data input in that same cycle, and `rsp_addr_o` equals the accepted address. Outside a beat, `beat_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Read request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_addr_i | input | ADDR_W | Line address of the read |
| req_id_i | input | IDW | Index of the requesting cache |
| snoop_i | input | 2*NUM_CACHES | Per-cache snoop state, 2 bits each |
| cache_data_i | input | NUM_CACHES*DATA_W | Per-cache beat data supplied on intervention |
| mem_data_i | input | DATA_W | Memory beat data |
| beat_valid_o | output | 1 | A data beat is on the bus this cycle |
| beat_idx_o | output | BEAT_W | Beat number within the line |
| beat_data_o | output | DATA_W | Beat data from the chosen source |
| rsp_addr_o | output | ADDR_W | Address of the line being served |
| src_mem_o | output | 1 | 1 when memory supplies the line |
| src_cache_o | output | IDW | Supplying cache index when not memory |

## Verification
Counting from the request cycle, beat k is due in cycle 6+k for a cache source and in cycle 14+k for memory. Ready is due back in the cycle after beat 3. A behavioural model in the bench advances one step per rising edge on the inputs seen there. The bench compares every output against this model half a cycle later, so every due cycle is checked exactly and early or late beats show up at once. Stray requests are issued while the block is busy, and one request is held pending so that the model confirms acceptance happens in the first ready cycle.

// File: rtl/snoop_resp_pkg.sv
// Package: snoop state decoding shared by the responder and its bench.
// Assumes 2 snoop bits per cache: bit 1 = modified, code 01 = shared.
package snoop_resp_pkg;

    // True when a snoop code reports the line held modified.
    function automatic logic snp_is_mod(input logic [1:0] code);
        return code[1];
    endfunction

    // True when a snoop code reports the line held shared only.
    function automatic logic snp_is_shr(input logic [1:0] code);
        return code == 2'b01;
    endfunction

endpackage

// File: rtl/snoop_select.sv
// Module: snoop_select
// Picks the intervening cache from the snoop reports. The requester is
// excluded, modified beats shared, and the lowest index wins within a class.
// Assumes NUM_CACHES >= 2. Purely combinational.
module snoop_select #(
    parameter int NUM_CACHES = 4,
    parameter int IDW        = 2
) (
    input  logic [2*NUM_CACHES-1:0] snoop_i,
    input  logic [IDW-1:0]          req_id_i,
    output logic                    hit_o,
    output logic [IDW-1:0]          win_o
);
    import snoop_resp_pkg::*;

    logic           mod_found;
    logic           shr_found;
    logic [IDW-1:0] mod_id;
    logic [IDW-1:0] shr_id;

    // Scan from the top index down so the lowest holder is kept last.
    always_comb begin
        mod_found = 1'b0;
        shr_found = 1'b0;
        mod_id    = '0;
        shr_id    = '0;
        for (int i = NUM_CACHES - 1; i >= 0; i--) begin
            if (IDW'(i) != req_id_i) begin
                if (snp_is_mod(snoop_i[2*i +: 2])) begin
                    mod_found = 1'b1;
                    mod_id    = IDW'(i);
                end else if (snp_is_shr(snoop_i[2*i +: 2])) begin
                    shr_found = 1'b1;
                    shr_id    = IDW'(i);
                end
            end
        end
    end

    // Modified holder has priority over shared holders.
    always_comb begin
        hit_o = mod_found | shr_found;
        win_o = mod_found ? mod_id : shr_id;
    end

endmodule

// File: rtl/burst_timer.sv
// Module: burst_timer
// Counts the cycles of one read from acceptance to the last beat. The lead
// time depends on the source. Beats run on consecutive cycles.
// Assumes 1 <= C2C_LAT <= MEM_LAT and BEATS a power of two >= 2.
module burst_timer #(
    parameter int C2C_LAT = 6,
    parameter int MEM_LAT = 14,
    parameter int BEATS   = 4,
    localparam int CW     = $clog2(MEM_LAT + BEATS + 1),
    localparam int BW     = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          from_mem_i,
    output logic          busy_o,
    output logic          beat_valid_o,
    output logic [BW-1:0] beat_idx_o
);
    localparam logic [CW-1:0] LAT_C = CW'(C2C_LAT);
    localparam logic [CW-1:0] LAT_M = CW'(MEM_LAT);
    localparam logic [CW-1:0] TAIL  = CW'(BEATS - 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lat_q;

    // Track cycle number since acceptance and the lead time of this read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            lat_q  <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                cnt_q  <= CW'(1);
                lat_q  <= from_mem_i ? LAT_M : LAT_C;
            end
        end else if (cnt_q == lat_q + TAIL) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Beat window is the last BEATS cycles of the busy period.
    always_comb begin
        busy_o       = busy_q;
        beat_valid_o = busy_q && (cnt_q >= lat_q);
        beat_idx_o   = BW'(cnt_q - lat_q);
    end

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && beat_idx_o != BW'(BEATS - 1)) |=>
        (beat_valid_o && beat_idx_o == $past(beat_idx_o) + BW'(1))); // R8

    AST_BURST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid_o) |-> beat_idx_o == '0); // R9

    AST_LAST_BEAT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && beat_idx_o == BW'(BEATS - 1)) |=> !busy_o); // R10

endmodule

// File: rtl/snoop_read_responder.sv
// Module: snoop_read_responder (top)
// Accepts one line read at a time and chooses a supplying cache or memory
// from the snoop reports. It drives the beat timing and passes the chosen
// source's data through. Assumes sources present beat data in the beat cycle.
module snoop_read_responder #(
    parameter int NUM_CACHES = 4,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int C2C_LAT    = 6,
    parameter int MEM_LAT    = 14,
    parameter int BEATS      = 4,
    localparam int IDW       = $clog2(NUM_CACHES),
    localparam int BEAT_W    = $clog2(BEATS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid_i,
    output logic                         req_ready_o,
    input  logic [ADDR_W-1:0]            req_addr_i,
    input  logic [IDW-1:0]               req_id_i,
    input  logic [2*NUM_CACHES-1:0]      snoop_i,
    input  logic [NUM_CACHES*DATA_W-1:0] cache_data_i,
    input  logic [DATA_W-1:0]            mem_data_i,
    output logic                         beat_valid_o,
    output logic [BEAT_W-1:0]            beat_idx_o,
    output logic [DATA_W-1:0]            beat_data_o,
    output logic [ADDR_W-1:0]            rsp_addr_o,
    output logic                         src_mem_o,
    output logic [IDW-1:0]               src_cache_o
);
    logic              hit;
    logic [IDW-1:0]    win;
    logic              busy;
    logic              accept;
    logic              src_mem_q;
    logic [IDW-1:0]    src_id_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] cache_sel;

    snoop_select #(
        .NUM_CACHES (NUM_CACHES),
        .IDW        (IDW)
    ) u_select (
        .snoop_i  (snoop_i),
        .req_id_i (req_id_i),
        .hit_o    (hit),
        .win_o    (win)
    );

    burst_timer #(
        .C2C_LAT (C2C_LAT),
        .MEM_LAT (MEM_LAT),
        .BEATS   (BEATS)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (accept),
        .from_mem_i   (!hit),
        .busy_o       (busy),
        .beat_valid_o (beat_valid_o),
        .beat_idx_o   (beat_idx_o)
    );

    // Request handshake: take a read only while idle.
    always_comb begin
        req_ready_o = !busy;
        accept      = req_valid_i && !busy;
    end

    // Capture source and address of the accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_mem_q <= 1'b1;
            src_id_q  <= '0;
            addr_q    <= '0;
        end else if (accept) begin
            src_mem_q <= !hit;
            src_id_q  <= win;
            addr_q    <= req_addr_i;
        end
    end

    // Select the supplying cache's data lane.
    always_comb begin
        cache_sel = '0;
        for (int i = 0; i < NUM_CACHES; i++) begin
            if (src_id_q == IDW'(i)) cache_sel = cache_data_i[i*DATA_W +: DATA_W];
        end
    end

    // Drive beat data and source report.
    always_comb begin
        beat_data_o = '0;
        if (beat_valid_o) beat_data_o = src_mem_q ? mem_data_i : cache_sel;
        rsp_addr_o  = addr_q;
        src_mem_o   = src_mem_q;
        src_cache_o = src_id_q;
    end

    AST_WIN_NOT_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && hit) |-> win != req_id_i); // R6

    AST_WIN_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && hit) |-> snoop_i[2*win +: 2] != 2'b00); // R2

    AST_SRC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && $past(beat_valid_o)) |->
        ($stable(src_mem_o) && $stable(src_cache_o) && $stable(rsp_addr_o))); // R10

    AST_NO_READY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> !req_ready_o); // R10

endmodule

// File: tb/snoop_read_responder_tb_top.sv
`timescale 1ns/1ps
module snoop_read_responder_tb_top;
    localparam int N   = 4;
    localparam int AW  = 32;
    localparam int DW  = 64;
    localparam int CL  = 6;
    localparam int ML  = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [AW-1:0]   req_addr = '0;
    logic [1:0]      req_id = '0;
    logic [2*N-1:0]  snoop = '0;
    logic [N*DW-1:0] cache_data = '0;
    logic [DW-1:0]   mem_data = '0;
    logic            beat_valid;
    logic [1:0]      beat_idx;
    logic [DW-1:0]   beat_data;
    logic [AW-1:0]   rsp_addr;
    logic            src_mem;
    logic [1:0]      src_cache;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    string cur_tag = "R1";

    // model state
    int    m_busy = 0, m_n = 0, m_lat = 0, m_mem = 1, m_id = 0;
    logic [AW-1:0] m_addr = '0;
    string m_tag = "R1";

    always #10 clk = ~clk;

    snoop_read_responder dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_addr_i(req_addr), .req_id_i(req_id), .snoop_i(snoop),
        .cache_data_i(cache_data), .mem_data_i(mem_data),
        .beat_valid_o(beat_valid), .beat_idx_o(beat_idx), .beat_data_o(beat_data),
        .rsp_addr_o(rsp_addr), .src_mem_o(src_mem), .src_cache_o(src_cache)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Source data lanes change every cycle so pass-through is visible.
    always @(negedge clk) begin
        cyc++;
        mem_data <= 64'hA500_0000_0000_0000 + 64'(cyc);
        for (int i = 0; i < N; i++)
            cache_data[i*DW +: DW] <= (64'(i + 1) << 56) + 64'(cyc);
    end

    // Reference model: one step per rising edge on the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_n = 0;
        end else if (m_busy == 0) begin
            if (req_valid) begin
                int mi, si;
                mi = -1; si = -1;
                for (int i = 0; i < N; i++)
                    if (i != int'(req_id) && snoop[2*i+1] && mi < 0) mi = i;
                for (int i = 0; i < N; i++)
                    if (i != int'(req_id) && snoop[2*i +: 2] == 2'b01 && si < 0) si = i;
                m_busy = 1; m_n = 1; m_addr = req_addr; m_tag = cur_tag;
                if (mi >= 0) begin m_mem = 0; m_id = mi; end
                else if (si >= 0) begin m_mem = 0; m_id = si; end
                else begin m_mem = 1; end
                m_lat = m_mem ? ML : CL;
            end
        end else if (m_n == m_lat + 3) begin
            m_busy = 0; m_n = 0;
        end else begin
            m_n++;
        end
    end

    // Compare every output half a cycle after each edge.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            logic ev;
            string ttag;
            ev = (m_busy != 0) && (m_n >= m_lat);
            ttag = m_mem ? "R9" : "R8";
            chk("R10", 64'(req_ready), 64'(m_busy == 0), "ready");
            chk(ttag, 64'(beat_valid), 64'(ev), "beat_valid");
            if (ev) begin
                logic [DW-1:0] ed;
                ed = m_mem ? mem_data : cache_data[m_id*DW +: DW];
                chk(ttag, 64'(beat_idx), 64'(m_n - m_lat), "beat_idx");
                chk(m_tag, 64'(src_mem), 64'(m_mem), "src_mem");
                if (m_mem == 0) chk(m_tag, 64'(src_cache), 64'(m_id), "src_cache");
                chk("R11", beat_data, ed, "beat_data");
                chk("R11", 64'(rsp_addr), 64'(m_addr), "rsp_addr");
            end else begin
                chk("R11", beat_data, 64'd0, "idle beat_data");
            end
        end
    end

    // Present one read, hold it until taken, optionally spray stray requests.
    task automatic do_req(input string tag, input int id, input logic [2*N-1:0] snp,
                          input logic [AW-1:0] addr, input bit stray, input bit chain);
        logic rdy;
        @(negedge clk);
        cur_tag = tag; req_valid = 1'b1; req_id = 2'(id); snoop = snp; req_addr = addr;
        do begin
            #1 rdy = req_ready;
            @(posedge clk);
            if (!rdy) @(negedge clk);
        end while (!rdy);
        @(negedge clk);
        req_valid = 1'b0; snoop = '0;
        if (stray) begin
            for (int k = 0; k < 4; k++) begin
                req_valid = 1'b1; req_id = 2'(k); snoop = 8'hAA; req_addr = 32'hDEAD_0000 + 32'(k);
                @(negedge clk);
            end
            req_valid = 1'b0; snoop = '0;
        end
        if (!chain) begin
            while (!req_ready) @(negedge clk);
        end
    endtask

    initial begin
        // R1: reset state, request during reset not taken
        req_valid = 1'b1; snoop = 8'h08;
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        chk("R1", 64'(req_ready), 64'd1, "ready in reset");
        chk("R1", 64'(beat_valid), 64'd0, "beat_valid in reset");
        chk("R1", beat_data, 64'd0, "beat_data in reset");
        req_valid = 1'b0; snoop = '0;
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_req("R2", 0, 8'b0010_0000, 32'h0000_1000, 0, 0); // cache2 modified
        do_req("R3", 1, 8'b0100_0000, 32'h0000_1040, 0, 0); // cache3 shared
        do_req("R4", 0, 8'b1000_0100, 32'h0000_1080, 0, 0); // c1 shared, c3 mod
        do_req("R5", 3, 8'b0001_0100, 32'h0000_10C0, 0, 0); // c1,c2 shared -> 1
        do_req("R5", 1, 8'b0010_0010, 32'h0000_1100, 0, 0); // c0,c2 mod -> 0
        do_req("R6", 1, 8'b0000_1000, 32'h0000_1140, 0, 0); // own mod -> memory
        do_req("R6", 2, 8'b0101_0000, 32'h0000_1180, 0, 0); // own shr, c3 shr -> 3
        do_req("R7", 0, 8'b0000_0000, 32'h0000_11C0, 0, 0); // nobody -> memory
        do_req("R2", 1, 8'b0011_0001, 32'h0000_1200, 0, 0); // c2 code 11 beats c0 shr
        do_req("R10", 2, 8'b0000_0010, 32'h0000_1240, 1, 1); // strays while busy
        do_req("R10", 0, 8'b0000_0000, 32'h0000_1280, 0, 0); // pending, taken at first ready
        do_req("R8", 3, 8'b0000_0001, 32'h0000_12C0, 0, 0);
        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 200000);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule